// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block owns the 32-bit floating-point status and control word of a scalar floating-point pipeline. Each time a valid strobe arrives, it folds in the exception causes that the arithmetic datapath has just raised, or it carries out one of the control operations on the word. These operations are: set one bit, clear one bit, load a nibble from an immediate, move masked fields from a 64-bit operand, and copy one field out to a condition register field. The block does no arithmetic. The exception causes come in as a ready-made vector at their final bit positions.

After every update, three summary bits are derived from the new word rather than stored directly. These are the invalid summary, the enabled-exception summary and the sticky any-exception flag. When requested, the block produces a 4-bit condition-field write, and it raises a trap request when an enabled exception is pending. Bit positions are fixed and counted from bit 31 downward, because the single-bit and field operations address the word by index from its most significant end.

Top module: `fpstat_unit`

## Requirements
- R1: A synchronous reset clears `stat` to zero. The word does not change in a cycle without `upd_vld`, and op codes 6 and 7 leave it unchanged.
- R2: Op 0 (merge) ORs into the word only the cause positions of `cause_in`: bits 28..19 and 10..8. All other input bits are ignored, and cause bits already set stay set.
- R3: After every update, bit 29 equals the OR of the invalid causes at bits 24..19 and 10..8.
- R4: After every update, bit 30 is 1 exactly when at least one of these pairs has both bits set: (29,7), (28,6), (27,5), (26,4), (25,3). Each enable sits 22 places below its cause.
- R5: Bit 31 becomes 1 when an op 0 or op 1 update turns any cause bit from 0 to 1. Otherwise it keeps its value after the operation.
- R6: Op 1 sets and op 2 clears bit (31 − `bit_sel`). Targeting bit 30 or bit 29 this way has no direct effect; those bits keep their derived values.
- R7: Op 3 writes `imm` into field `fld_sel`, where field k is bits [31−4k : 28−4k].
- R8: Op 4 replaces every field i (bits [4i+3:4i]) whose `fld_mask[i]` is 1 with the same bits of `src[31:0]`. A mask of 8'hFF replaces the whole word.
- R9: Op 5 drives `cond_val` with field `fld_sel` of the old word and `cond_idx` with `dst_fld`, and pulses `cond_we`. Within that field it clears only bit 31 and the cause bits.
- R10: With `rec` high on an op other than 5, `cond_we` pulses with `cond_idx` = 1 and `cond_val` = bits 31..28 of the new word.
- R11: `trap_req` pulses, in step with the new word, on every update that leaves bit 30 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_vld | input | 1 | Update strobe |
| op | input | 3 | Operation code (0 merge, 1 set bit, 2 clear bit, 3 nibble immediate, 4 masked move, 5 field to condition) |
| rec | input | 1 | Record the new top field to condition field 1 |
| cause_in | input | 32 | Newly raised exception causes |
| bit_sel | input | 5 | Bit index counted from the MSB |
| fld_sel | input | 3 | Field index counted from the MSB |
| imm | input | 4 | Nibble immediate |
| fld_mask | input | 8 | Field mask for the masked move |
| dst_fld | input | 3 | Destination condition field for op 5 |
| src | input | 64 | Source operand for the masked move |
| stat | output | 32 | Status and control word |
| cond_we | output | 1 | Condition-field write pulse |
| cond_idx | output | 3 | Condition-field index |
| cond_val | output | 4 | Condition-field value |
| trap_req | output | 1 | Enabled-exception trap request |

## Verification
On every cycle, the assertions check that both derived summaries agree with the stored word, that a held strobe freezes the word, that a merge never drops a cause, and that a trap or condition pulse only follows a real update. The bench scenarios are needed for the rest: the per-operation effects on specific bit and field positions, the protection of bits 30 and 29 against single-bit writes, the selective clearing done by the field-to-condition copy, and when the sticky flag gets raised.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
   typedef enum logic [2:0] {
      OP_MERGE   = 3'd0,
      OP_BSET    = 3'd1,
      OP_BCLR    = 3'd2,
      OP_NIBIMM  = 3'd3,
      OP_MASKMOV = 3'd4,
      OP_FLD2CR  = 3'd5
   } fs_op_e;

   // exception cause positions (overflow..inexact, invalid causes)
   localparam logic [31:0] CAUSE_BITS  = 32'h1FF8_0700;
   // invalid-operation causes only
   localparam logic [31:0] INV_BITS    = 32'h01F8_0700;
   // derived summaries that single-bit writes cannot touch
   localparam logic [31:0] PROT_BITS   = 32'h6000_0000;
   // bits the field-to-condition copy may clear
   localparam logic [31:0] F2C_CLR     = 32'h9FF8_0700;

   localparam int POS_ANY  = 31;
   localparam int POS_EN   = 30;
   localparam int POS_INV  = 29;
   localparam int EN_LO    = 3;
   localparam int EN_SHIFT = 22;
   localparam int EN_CNT   = 5;
endpackage

// File: rtl/fpstat_mask_expand.sv
module fpstat_mask_expand #(
   parameter int NFLD = 8,
   parameter int FW   = 4
) (
   input  logic [NFLD-1:0]    fmask,
   output logic [NFLD*FW-1:0] wmask
);
   for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
      assign wmask[gi*FW +: FW] = {FW{fmask[gi]}};
   end
endmodule

// File: rtl/fpstat_opmux.sv
module fpstat_opmux
   import fpstat_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int SRC_W = 64,
   parameter int FW    = 4,
   localparam int NFLD = REG_W / FW,
   localparam int BW   = $clog2(REG_W),
   localparam int FSW  = $clog2(NFLD)
) (
   input  logic [REG_W-1:0] cur,
   input  logic [2:0]       op,
   input  logic [REG_W-1:0] cause,
   input  logic [BW-1:0]    bsel,
   input  logic [FSW-1:0]   fsel,
   input  logic [FW-1:0]    imm,
   input  logic [NFLD-1:0]  fmask,
   input  logic [SRC_W-1:0] src,
   output logic [REG_W-1:0] pre,
   output logic             arm_any,
   output logic [FW-1:0]    fld_out
);
   logic [REG_W-1:0] wmask;
   logic [REG_W-1:0] bit_oh;
   logic [REG_W-1:0] nib_m;
   logic [REG_W-1:0] imm_w;
   int               nib_sh;

   fpstat_mask_expand #(.NFLD(NFLD), .FW(FW)) u_mexp (
      .fmask (fmask),
      .wmask (wmask)
   );

   always_comb begin
      nib_sh = REG_W - FW * (int'(fsel) + 1);
      bit_oh = {{(REG_W-1){1'b0}}, 1'b1} << (REG_W - 1 - int'(bsel));
      nib_m  = {{(REG_W-FW){1'b0}}, {FW{1'b1}}} << nib_sh;
      imm_w  = {{(REG_W-FW){1'b0}}, imm} << nib_sh;
      fld_out = FW'(cur >> nib_sh);
   end

   always_comb begin
      arm_any = 1'b0;
      pre     = cur;
      unique case (op)
         OP_MERGE: begin
            pre     = cur | (cause & CAUSE_BITS);
            arm_any = 1'b1;
         end
         OP_BSET: begin
            pre     = cur | (bit_oh & ~PROT_BITS);
            arm_any = 1'b1;
         end
         OP_BCLR:    pre = cur & ~(bit_oh & ~PROT_BITS);
         OP_NIBIMM:  pre = (cur & ~nib_m) | imm_w;
         OP_MASKMOV: pre = (cur & ~wmask) | (src[REG_W-1:0] & wmask);
         OP_FLD2CR:  pre = cur & ~(nib_m & F2C_CLR);
         default:    pre = cur;
      endcase
   end
endmodule

// File: rtl/fpstat_summary.sv
module fpstat_summary
   import fpstat_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic [REG_W-1:0] cur,
   input  logic [REG_W-1:0] pre,
   input  logic             arm_any,
   output logic [REG_W-1:0] nxt
);
   logic               inv_s;
   logic [EN_CNT-1:0]  cause5;
   logic [EN_CNT-1:0]  en5;
   logic               en_s;
   logic               new_cause;

   always_comb begin
      inv_s     = |(pre & INV_BITS);
      cause5    = {inv_s, pre[POS_INV-1 -: EN_CNT-1]};
      en5       = pre[EN_LO +: EN_CNT];
      en_s      = |(cause5 & en5);
      new_cause = |(pre & ~cur & CAUSE_BITS);
      nxt       = pre;
      nxt[POS_INV] = inv_s;
      nxt[POS_EN]  = en_s;
      nxt[POS_ANY] = pre[POS_ANY] | (arm_any & new_cause);
   end
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
   import fpstat_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int SRC_W   = 64,
   parameter int FW      = 4,
   parameter int REC_FLD = 1,
   localparam int NFLD = REG_W / FW,
   localparam int BW   = $clog2(REG_W),
   localparam int FSW  = $clog2(NFLD)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             upd_vld,
   input  logic [2:0]       op,
   input  logic             rec,
   input  logic [31:0]      cause_in,
   input  logic [4:0]       bit_sel,
   input  logic [2:0]       fld_sel,
   input  logic [3:0]       imm,
   input  logic [7:0]       fld_mask,
   input  logic [2:0]       dst_fld,
   input  logic [63:0]      src,
   output logic [31:0]      stat,
   output logic             cond_we,
   output logic [2:0]       cond_idx,
   output logic [3:0]       cond_val,
   output logic             trap_req
);
   if (REG_W != 32) begin : g_bad_width
      $error("fpstat_unit: bit layout requires REG_W == 32");
   end
   if (FW != 4 || NFLD != 8) begin : g_bad_field
      $error("fpstat_unit: layout requires eight 4-bit fields");
   end
   if (SRC_W < REG_W) begin : g_bad_src
      $error("fpstat_unit: SRC_W must cover REG_W");
   end
   if (REC_FLD >= NFLD) begin : g_bad_rec
      $error("fpstat_unit: REC_FLD out of range");
   end

   logic [REG_W-1:0] pre;
   logic [REG_W-1:0] nxt;
   logic             arm_any;
   logic [FW-1:0]    fld_old;
   logic [REG_W-1:0] stat_q;

   fpstat_opmux #(.REG_W(REG_W), .SRC_W(SRC_W), .FW(FW)) u_opmux (
      .cur     (stat_q),
      .op      (op),
      .cause   (cause_in),
      .bsel    (bit_sel),
      .fsel    (fld_sel),
      .imm     (imm),
      .fmask   (fld_mask),
      .src     (src),
      .pre     (pre),
      .arm_any (arm_any),
      .fld_out (fld_old)
   );

   fpstat_summary #(.REG_W(REG_W)) u_sum (
      .cur     (stat_q),
      .pre     (pre),
      .arm_any (arm_any),
      .nxt     (nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q   <= '0;
         cond_we  <= 1'b0;
         cond_idx <= '0;
         cond_val <= '0;
         trap_req <= 1'b0;
      end else begin
         cond_we  <= 1'b0;
         trap_req <= 1'b0;
         if (upd_vld) begin
            stat_q   <= nxt;
            trap_req <= nxt[POS_EN];
            if (op == OP_FLD2CR) begin
               cond_we  <= 1'b1;
               cond_idx <= dst_fld;
               cond_val <= fld_old;
            end else if (rec) begin
               cond_we  <= 1'b1;
               cond_idx <= 3'(REC_FLD);
               cond_val <= nxt[REG_W-1 -: FW];
            end
         end
      end
   end

   assign stat = stat_q;
endmodule

// File: rtl/fpstat_chk.sv
module fpstat_chk
   import fpstat_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic        upd_vld,
   input logic [2:0]  op,
   input logic [31:0] stat,
   input logic        cond_we,
   input logic        trap_req
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> stat == 32'h0);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !upd_vld |=> $stable(stat));

   // R2
   merge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (upd_vld && op == 3'd0) |=> ((stat & $past(stat) & CAUSE_BITS) == ($past(stat) & CAUSE_BITS)));

   // R3
   inv_summary_chk: assert property (@(posedge clk) disable iff (rst)
      stat[POS_INV] == |(stat & INV_BITS));

   // R4
   en_summary_chk: assert property (@(posedge clk) disable iff (rst)
      stat[POS_EN] == |({stat[POS_INV], stat[28:25]} & stat[7:3]));

   // R11
   trap_match_chk: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> stat[POS_EN]);

   // R11
   trap_only_upd_chk: assert property (@(posedge clk) disable iff (rst)
      !upd_vld |=> !trap_req);

   // R10
   cond_only_upd_chk: assert property (@(posedge clk) disable iff (rst)
      !upd_vld |=> !cond_we);
endmodule

bind fpstat_unit fpstat_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .upd_vld  (upd_vld),
   .op       (op),
   .stat     (stat),
   .cond_we  (cond_we),
   .trap_req (trap_req)
);

// File: tb/test_fpstat_unit.sv
`timescale 1ns/1ps
module test_fpstat_unit;
   localparam logic [31:0] CAUSE_M = 32'h1FF8_0700;
   localparam logic [31:0] INV_M   = 32'h01F8_0700;

   typedef struct {
      logic [31:0] st;
      logic        we;
      logic [2:0]  idx;
      logic [3:0]  val;
      logic        trap;
      string       tag;
   } exp_t;

   logic        clk = 0;
   logic        rst = 1;
   logic        upd_vld = 0;
   logic [2:0]  op = 0;
   logic        rec = 0;
   logic [31:0] cause_in = 0;
   logic [4:0]  bit_sel = 0;
   logic [2:0]  fld_sel = 0;
   logic [3:0]  imm = 0;
   logic [7:0]  fld_mask = 0;
   logic [2:0]  dst_fld = 0;
   logic [63:0] src = 0;
   logic [31:0] stat;
   logic        cond_we;
   logic [2:0]  cond_idx;
   logic [3:0]  cond_val;
   logic        trap_req;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] mdl = 0;
   exp_t q[$];
   bit done = 0;

   always #10 clk = ~clk;

   fpstat_unit i_fpstat_unit (
      .clk(clk), .rst(rst), .upd_vld(upd_vld), .op(op), .rec(rec),
      .cause_in(cause_in), .bit_sel(bit_sel), .fld_sel(fld_sel), .imm(imm),
      .fld_mask(fld_mask), .dst_fld(dst_fld), .src(src), .stat(stat),
      .cond_we(cond_we), .cond_idx(cond_idx), .cond_val(cond_val),
      .trap_req(trap_req)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] field_mask(int k);
      return 32'hF000_0000 >> (4 * k);
   endfunction

   task automatic apply(int o, logic r, logic [31:0] c, int n, int fs, logic [3:0] im,
                        logic [7:0] fm, int df, logic [63:0] s, string tag);
      logic [31:0] pre, wm, nxt;
      logic        vx, fex, arm;
      exp_t e;
      @(negedge clk);
      upd_vld = 1; op = 3'(o); rec = r; cause_in = c; bit_sel = 5'(n);
      fld_sel = 3'(fs); imm = im; fld_mask = fm; dst_fld = 3'(df); src = s;
      pre = mdl; arm = 0;
      wm = 0;
      for (int i = 0; i < 8; i++) if (fm[i]) wm[4*i +: 4] = 4'hF;
      case (o)
         0: begin pre = mdl | (c & CAUSE_M); arm = 1; end
         1: begin if (n != 1 && n != 2) pre[31-n] = 1'b1; arm = 1; end
         2: if (n != 1 && n != 2) pre[31-n] = 1'b0;
         3: pre = (mdl & ~field_mask(fs)) | ({28'h0, im} << (28 - 4*fs));
         4: pre = (mdl & ~wm) | (s[31:0] & wm);
         5: pre = mdl & ~(field_mask(fs) & 32'h9FF8_0700);
         default: pre = mdl;
      endcase
      vx  = |(pre & INV_M);
      fex = (vx & pre[7]) | (pre[28] & pre[6]) | (pre[27] & pre[5]) |
            (pre[26] & pre[4]) | (pre[25] & pre[3]);
      nxt = pre;
      nxt[29] = vx;
      nxt[30] = fex;
      nxt[31] = pre[31] | (arm & |(pre & ~mdl & CAUSE_M));
      e.st = nxt; e.trap = fex; e.tag = tag;
      if (o == 5) begin
         e.we = 1; e.idx = 3'(df); e.val = 4'(mdl >> (28 - 4*fs));
      end else if (r) begin
         e.we = 1; e.idx = 3'd1; e.val = nxt[31:28];
      end else begin
         e.we = 0; e.idx = 0; e.val = 0;
      end
      mdl = nxt;
      q.push_back(e);
   endtask

   task automatic idle(string tag);
      exp_t e;
      @(negedge clk);
      upd_vld = 0; op = 3'd0; cause_in = 32'hFFFF_FFFF; rec = 1;
      e.st = mdl; e.we = 0; e.idx = 0; e.val = 0; e.trap = 0; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: pops one expected item per driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "stat", stat, e.st);
            check(e.tag, "cond_we", {31'h0, cond_we}, {31'h0, e.we});
            if (e.we) begin
               check(e.tag, "cond_idx", {29'h0, cond_idx}, {29'h0, e.idx});
               check(e.tag, "cond_val", {28'h0, cond_val}, {28'h0, e.val});
            end
            check(e.tag, "trap_req", {31'h0, trap_req}, {31'h0, e.trap});
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      check("R1", "reset stat", stat, 32'h0);
      check("R1", "reset trap", {31'h0, trap_req}, 32'h0);
      idle("R1");
      apply(0, 0, 32'h0100_0000, 0, 0, 0, 0, 0, 0, "R3");       // SNaN cause
      apply(2, 0, 0, 0, 0, 0, 0, 0, 0, "R6");                   // clear bit 31
      apply(0, 0, 32'h0104_0000, 0, 0, 0, 0, 0, 0, "R2");       // bit 18 ignored, no new cause
      apply(1, 0, 0, 1, 0, 0, 0, 0, 0, "R6");                   // bit 30 protected
      apply(2, 0, 0, 2, 0, 0, 0, 0, 0, "R6");                   // bit 29 protected
      apply(3, 0, 0, 0, 6, 4'h8, 0, 0, 0, "R11");               // invalid enable on
      apply(5, 0, 0, 0, 1, 0, 0, 3, 0, "R9");                   // field 1 to cond 3
      apply(0, 1, 32'h1000_0000, 0, 0, 0, 0, 0, 0, "R10");      // overflow, record
      apply(1, 0, 0, 25, 0, 0, 0, 0, 0, "R4");                  // overflow enable
      apply(5, 0, 0, 0, 0, 0, 0, 6, 0, "R9");                   // top field out, clears FX/OX
      apply(4, 0, 0, 0, 0, 0, 8'hFF, 0, 64'hDEAD_BEEF_0000_0000, "R8");
      apply(4, 0, 0, 0, 0, 0, 8'h01, 0, 64'hFFFF_FFFF_1234_56F9, "R8");
      apply(3, 0, 0, 0, 1, 4'h2, 0, 0, 0, "R7");                // field 1 = 0010
      apply(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R5");       // all causes
      apply(6, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R1");       // reserved op
      apply(4, 0, 0, 0, 0, 0, 8'h00, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
      idle("R1");
      idle("R11");
      @(negedge clk);
      upd_vld = 0;
      repeat (3) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule